// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block finds the serial bit rate of a host by timing the characters the host sends, so that the UART needs no fixed divisor. The host transmits the byte 0x00 over and over. On the line, each such character is low for nine bit times: the start bit and the eight zero data bits. The block passes the raw receive line through a synchronizer and counts system clocks for as long as the line is low. It divides that count by nine, rounding to the nearest integer, to get the clocks per bit.

Two measurements in a row must agree to within one count. When they do, the block latches the clocks-per-bit value minus one as the divisor for the UART transmitter and receiver, and raises a lock flag. Low periods that are too short or too long to be valid set an error flag and are discarded. Dropping the enable input clears the result so that calibration can be run again. Sending a confirmation byte and any later protocol steps belong to the surrounding logic.

Top module: `autobaud_detect`

## Requirements
- R1: With the block enabled and the line idle high, a low period of L clocks, counted after the synchronizer, yields a candidate bit time of floor((L+4)/9), which is L/9 rounded to the nearest integer. The synchronizer has SYNC_STAGES flops, two by default.
- R2: When two consecutive valid candidates differ by at most 1, lockOut rises and divisorOut becomes the second candidate minus 1.
- R3: When two consecutive valid candidates differ by more than 1, the block does not lock. The second candidate becomes the new reference, and one more agreeing candidate is needed.
- R4: A low period shorter than 9*MIN_BIT_CLKS clocks sets errOut and is discarded. Any stored reference candidate is dropped with it.
- R5: A low period longer than 2^CNT_W-1 clocks sets errOut and is discarded, and the reference is dropped. A period of exactly 2^CNT_W-1 clocks is still valid.
- R6: errOut stays set until the next valid measurement, which clears it.
- R7: While lockOut is 0, divisorOut reads 0.
- R8: Once locked, lockOut and divisorOut hold their values whatever the receive line does, for as long as enable stays high.
- R9: While enable is low, lockOut, errOut and divisorOut are 0 and activity on the receive line has no effect.
- R10: A low period that is already in progress when enable rises is not measured. Measuring starts only after the line has been seen high.
- R11: After reset, divisorOut, lockOut and errOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Calibration enable; low clears the result and ignores the line |
| rxIn | input | 1 | Raw asynchronous serial receive line, idle high |
| divisorOut | output | CNT_W-3 | Clocks per bit minus one, valid while lockOut is high |
| lockOut | output | 1 | Two agreeing measurements have been taken |
| errOut | output | 1 | The last low period was out of range |

## Verification
The bench builds the block with CNT_W = 12 and MIN_BIT_CLKS = 9. This puts the upper limit of 4095 clocks within a few thousand cycles of stimulus, so the low periods of 4095 and 4096 clocks both get driven. The lower limit of 81 clocks is tested next to a period of 80 clocks. Because the counter is small, a character can be timed to the exact clock, so rounding just above and just below the half-bit point, the ±1 agreement window, and the way a rejected character resets the reference can each be checked against hand-computed divisors.

// File: rtl/abd_pkg.sv
package abd_pkg;

  typedef enum logic [2:0] {
    S_ARM,
    S_IDLE,
    S_LOW,
    S_DIV,
    S_EVAL,
    S_LOCK
  } abdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic divStart;
    logic saveRef;
    logic loadDiv;
    logic clearDiv;
  } abdStrobe_t;

  // datapath conditions seen by control
  typedef struct packed {
    logic rxLow;
    logic cntFull;
    logic tooShort;
    logic divDone;
    logic agree;
  } abdStatus_t;

endpackage

// File: rtl/abd_datapath.sv
module abd_datapath
  import abd_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter int MIN_BIT_CLKS = 9,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rxIn,
  input  abdStrobe_t         strb,
  output abdStatus_t         stat,
  output logic [CNT_W-4:0]   divisorQ
);

  localparam int DIV_W   = CNT_W - 3;
  localparam int DVD_W   = CNT_W + 1;
  localparam int BC_W    = $clog2(DVD_W + 1);
  localparam int MIN_LOW = 9 * MIN_BIT_CLKS;
  localparam int PW      = DVD_W + 4;

  // input synchronizer, idle level high
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
  end
  wire rxLow = !syncQ[SYNC_STAGES-1];

  // saturating low-period counter
  logic [CNT_W-1:0] lowCnt;
  wire cntFull = &lowCnt;
  always_ff @(posedge clk) begin
    if (rst)                          lowCnt <= '0;
    else if (strb.cntClear)           lowCnt <= '0;
    else if (strb.cntInc && !cntFull) lowCnt <= lowCnt + CNT_W'(1);
  end

  // restoring divide of (count + 4) by nine, one quotient bit per cycle
  logic [DVD_W-1:0] dvdReg, shReg;
  logic [DIV_W-1:0] quotReg;
  logic [3:0]       remReg;
  logic [BC_W-1:0]  bitCnt;
  logic             divBusy, divDone;
  logic [4:0]       trial;
  assign trial = {remReg, shReg[DVD_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dvdReg  <= '0;
      shReg   <= '0;
      quotReg <= '0;
      remReg  <= '0;
      bitCnt  <= '0;
      divBusy <= 1'b0;
      divDone <= 1'b0;
    end else begin
      divDone <= 1'b0;
      if (strb.divStart) begin
        dvdReg  <= {1'b0, lowCnt} + DVD_W'(4);
        shReg   <= {1'b0, lowCnt} + DVD_W'(4);
        quotReg <= '0;
        remReg  <= '0;
        bitCnt  <= BC_W'(DVD_W);
        divBusy <= 1'b1;
      end else if (divBusy) begin
        if (trial >= 5'd9) begin
          remReg  <= 4'(trial - 5'd9);
          quotReg <= {quotReg[DIV_W-2:0], 1'b1};
        end else begin
          remReg  <= trial[3:0];
          quotReg <= {quotReg[DIV_W-2:0], 1'b0};
        end
        shReg  <= {shReg[DVD_W-2:0], 1'b0};
        bitCnt <= bitCnt - BC_W'(1);
        if (bitCnt == BC_W'(1)) begin
          divBusy <= 1'b0;
          divDone <= 1'b1;
        end
      end
    end
  end

  // reference candidate and agreement window
  logic [DIV_W-1:0] refQ, qDiff;
  always_ff @(posedge clk) begin
    if (rst)               refQ <= '0;
    else if (strb.saveRef) refQ <= quotReg;
  end
  assign qDiff = (quotReg >= refQ) ? (quotReg - refQ) : (refQ - quotReg);

  // divisor register
  always_ff @(posedge clk) begin
    if (rst)                divisorQ <= '0;
    else if (strb.clearDiv) divisorQ <= '0;
    else if (strb.loadDiv)  divisorQ <= quotReg - DIV_W'(1);
  end

  assign stat.rxLow    = rxLow;
  assign stat.cntFull  = cntFull;
  assign stat.tooShort = lowCnt < CNT_W'(MIN_LOW);
  assign stat.divDone  = divDone;
  assign stat.agree    = qDiff <= DIV_W'(1);

  // quotient is the true floor of the latched dividend over nine
  logic [PW-1:0] qTimes9;
  assign qTimes9 = PW'(quotReg) * PW'(9);
  p_quot_floor_r1: assert property (@(posedge clk) disable iff (rst)
    divDone |-> (qTimes9 <= PW'(dvdReg)) && (PW'(dvdReg) < qTimes9 + PW'(9)));

  // the counter saturates rather than wrapping
  p_cnt_saturate_r5: assert property (@(posedge clk) disable iff (rst)
    (cntFull && strb.cntInc && !strb.cntClear) |=> cntFull);

endmodule

// File: rtl/abd_ctrl.sv
module abd_ctrl
  import abd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  abdStatus_t stat,
  output abdStrobe_t strb,
  output logic       lockOut,
  output logic       errOut
);

  abdState_e state, stateNext;
  logic haveRef, badMeas, goodMeas;

  always_comb begin
    strb      = '0;
    stateNext = state;
    badMeas   = 1'b0;
    goodMeas  = 1'b0;
    case (state)
      S_ARM: begin
        strb.cntClear = 1'b1;
        if (!stat.rxLow) stateNext = S_IDLE;
      end
      S_IDLE: begin
        if (stat.rxLow) begin
          strb.cntInc = 1'b1;
          stateNext   = S_LOW;
        end else begin
          strb.cntClear = 1'b1;
        end
      end
      S_LOW: begin
        if (stat.rxLow) begin
          if (stat.cntFull) begin
            badMeas   = 1'b1;
            stateNext = S_ARM;
          end else begin
            strb.cntInc = 1'b1;
          end
        end else if (stat.tooShort) begin
          badMeas   = 1'b1;
          stateNext = S_IDLE;
        end else begin
          strb.divStart = 1'b1;
          stateNext     = S_DIV;
        end
      end
      S_DIV: begin
        if (stat.divDone) stateNext = S_EVAL;
      end
      S_EVAL: begin
        goodMeas = 1'b1;
        if (haveRef && stat.agree) begin
          strb.loadDiv = 1'b1;
          stateNext    = S_LOCK;
        end else begin
          strb.saveRef = 1'b1;
          stateNext    = S_ARM;
        end
      end
      S_LOCK: stateNext = S_LOCK;
      default: stateNext = S_ARM;
    endcase
    if (!enable) begin
      strb          = '0;
      strb.cntClear = 1'b1;
      strb.clearDiv = 1'b1;
      stateNext     = S_ARM;
      badMeas       = 1'b0;
      goodMeas      = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_ARM;
      haveRef <= 1'b0;
      lockOut <= 1'b0;
      errOut  <= 1'b0;
    end else begin
      state <= stateNext;
      if (!enable) begin
        haveRef <= 1'b0;
        lockOut <= 1'b0;
        errOut  <= 1'b0;
      end else begin
        if (badMeas) begin
          errOut  <= 1'b1;
          haveRef <= 1'b0;
        end
        if (goodMeas)     errOut  <= 1'b0;
        if (strb.saveRef) haveRef <= 1'b1;
        if (strb.loadDiv) lockOut <= 1'b1;
      end
    end
  end

  p_lock_on_agree_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lockOut) |-> $past(stat.agree && haveRef));

  p_err_from_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(errOut) |-> $past(state == S_LOW));

  p_lock_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && $past(lockOut)) |-> lockOut);

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!lockOut && !errOut));

endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect
  import abd_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter int MIN_BIT_CLKS = 9,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             rxIn,
  output logic [CNT_W-4:0] divisorOut,
  output logic             lockOut,
  output logic             errOut
);

  abdStrobe_t strb;
  abdStatus_t stat;

  abd_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .stat    (stat),
    .strb    (strb),
    .lockOut (lockOut),
    .errOut  (errOut)
  );

  abd_datapath #(
    .CNT_W        (CNT_W),
    .MIN_BIT_CLKS (MIN_BIT_CLKS),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .rxIn     (rxIn),
    .strb     (strb),
    .stat     (stat),
    .divisorQ (divisorOut)
  );

  p_zero_unlocked_r7: assert property (@(posedge clk) disable iff (rst)
    !lockOut |-> (divisorOut == '0));

  p_div_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (lockOut && $past(lockOut)) |-> $stable(divisorOut));

endmodule

// File: tb/test_autobaud_detect.sv
`timescale 1ns/1ps
module test_autobaud_detect;

  localparam int CNT_W = 12;
  localparam int GAP   = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic rxIn = 1'b1;
  logic [CNT_W-4:0] divisorOut;
  logic lockOut, errOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  autobaud_detect #(.CNT_W(CNT_W), .MIN_BIT_CLKS(9), .SYNC_STAGES(2)) i_autobaud_detect (
    .clk(clk), .rst(rst), .enable(enable), .rxIn(rxIn),
    .divisorOut(divisorOut), .lockOut(lockOut), .errOut(errOut)
  );

  // low1, low2, expected lock, expected divisor
  localparam int VEC [8][4] = '{
    '{900,  900,  1, 99},
    '{900,  913,  1, 100},
    '{900,  940,  0, 0},
    '{81,   81,   1, 8},
    '{103,  104,  1, 11},
    '{4000, 4000, 1, 443},
    '{1000, 1012, 1, 111},
    '{80,   900,  0, 0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lowFor(input int n);
    rxIn = 1'b0;
    repeat (n) @(negedge clk);
    rxIn = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic rearm();
    enable = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 div", int'(divisorOut), 0);
    check("R11 lock", int'(lockOut), 0);
    check("R11 err", int'(errOut), 0);

    for (int i = 0; i < 8; i++) begin
      rearm();
      lowFor(VEC[i][0]);
      lowFor(VEC[i][1]);
      check($sformatf("R1 R2 R3 vec%0d lock", i), int'(lockOut), VEC[i][2]);
      check($sformatf("R2 R7 vec%0d div", i), int'(divisorOut), VEC[i][3]);
      check($sformatf("R6 vec%0d err", i), int'(errOut), 0);
    end

    // R3: after a disagreement the later candidate is the reference
    rearm();
    lowFor(900); lowFor(940);
    check("R3 no lock", int'(lockOut), 0);
    lowFor(940);
    check("R3 lock", int'(lockOut), 1);
    check("R3 div", int'(divisorOut), 103);

    // R4, R6: short period flags error, next valid clears it
    rearm();
    lowFor(80);
    check("R4 err", int'(errOut), 1);
    check("R4 lock", int'(lockOut), 0);
    lowFor(900);
    check("R6 err cleared", int'(errOut), 0);
    check("R6 lock", int'(lockOut), 0);

    // R4: rejected period drops the reference
    rearm();
    lowFor(900); lowFor(80); lowFor(900);
    check("R4 ref dropped", int'(lockOut), 0);
    lowFor(900);
    check("R4 relock", int'(lockOut), 1);
    check("R4 relock div", int'(divisorOut), 99);

    // R5: upper limit
    rearm();
    lowFor(4096);
    check("R5 overflow err", int'(errOut), 1);
    lowFor(4095); lowFor(4095);
    check("R5 max lock", int'(lockOut), 1);
    check("R5 max div", int'(divisorOut), 454);
    check("R5 err cleared", int'(errOut), 0);

    // R8: locked result holds
    lowFor(2000); lowFor(2000); lowFor(50);
    check("R8 lock held", int'(lockOut), 1);
    check("R8 div held", int'(divisorOut), 454);
    check("R8 no err", int'(errOut), 0);

    // R9: disable clears and ignores the line
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 lock", int'(lockOut), 0);
    check("R9 div", int'(divisorOut), 0);
    lowFor(900); lowFor(900); lowFor(50);
    check("R9 ignored lock", int'(lockOut), 0);
    check("R9 ignored err", int'(errOut), 0);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    lowFor(50);
    check("R9 err set", int'(errOut), 1);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 err cleared", int'(errOut), 0);

    // R10: period in progress at enable is not measured
    rxIn = 1'b0;
    repeat (10) @(negedge clk);
    enable = 1'b1;
    repeat (900) @(negedge clk);
    rxIn = 1'b1;
    repeat (GAP) @(negedge clk);
    lowFor(900);
    check("R10 partial ignored", int'(lockOut), 0);
    lowFor(900);
    check("R10 lock", int'(lockOut), 1);
    check("R10 div", int'(divisorOut), 99);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule